// File: doc/BRIEF.md
# Software-Clocked Pad Configuration Shift Chains

This block turns one host-writable control byte into the strobes of two serial configuration chains for the GPIO pads. Each chain is a row of pad slots, and each slot is a 13-bit shift word. Every slot also holds a 13-bit active configuration that the pad uses. The host makes the chain clock, serial data, chain clear and load strobe itself, one field per write. One register write sets the data bits. The next write raises the shared clock bit, and the next one lowers it. When every word is in place, a load write copies all shift words into the active configurations at the same time.

Both chains share the clock, clear and load fields, and each chain has its own data field. Words go in most-significant bit first. A word enters at slot 0. Every further group of 13 clocks moves it one slot farther along, so the host reaches distant slots by shifting more words in behind it. The block detects edges on the register fields inside its own clock domain. It has no sequencer.

Top module: `gpio_cfg_chain_ctrl`

## Requirements
- R1: A write takes effect only when `wr_stb` is high and `wr_addr` equals the parameter `CTL_ADDR` (default 0x13). The data byte then becomes the control value. A write to any other address changes nothing.
- R2: The control byte fields are: bit 1 enable, bit 2 chain run (active low clear), bit 3 load, bit 4 chain clock, bit 5 chain A data, bit 6 chain B data. Bits 0 and 7 have no function.
- R3: Each 0-to-1 change of the clock bit shifts both chains by exactly one position. A clock bit that stays high does not shift again. The first write after reset does not shift if its clock bit is 0.
- R4: A shift moves the data bit into bit 0 of slot 0, and bit 12 of slot k into bit 0 of slot k+1. After 13 shifts, a word sent MSB first sits in slot 0 unchanged. Each further 13 shifts move it one slot farther along the chain.
- R5: Chain B shifts on the same edges as chain A and takes its own data bit. The two chains never exchange bits.
- R6: While the enable bit is 0, the clock, data, load and run bits are ignored. No shift word and no active configuration changes.
- R7: While enable is 1 and the run bit is 0, every shift word is cleared and held at zero, and clock edges do not shift.
- R8: A 0-to-1 change of the load bit while enabled copies every shift word into its slot's active configuration. Otherwise the active configurations hold their values.
- R9: Reset (`rst_n` low, asserted asynchronously and released synchronously) clears the control value and the shift words, and sets every active configuration to `CFG_RST` (default 0x1809).
- R10: If one write raises the load and clock bits together, the active configurations take the words as they were before that shift, and the chains still shift once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 8 | Host register address |
| wr_data | input | 8 | Host write data |
| cfg_a_o | output | NPADS*13 | Chain A active configurations, slot k at bits [13k+12:13k] |
| cfg_b_o | output | NPADS*13 | Chain B active configurations, slot k at bits [13k+12:13k] |

## Verification
The load copy and the chain shift can happen on the same clock edge. The test provokes this with a single write that raises both the clock bit and the load bit. It is judged in two steps. Straight after that write, the active configurations must show the words as they were before the shift. A later plain load must then show the words moved by one bit, with the new data bit at slot 0 bit 0.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
  localparam int CFG_W = 13;
  localparam int CTL_W = 8;

  // Control byte layout; bit 0 is the least significant member (xfer)
  typedef struct packed {
    logic spare;
    logic db;
    logic da;
    logic sclk;
    logic load;
    logic run_n;
    logic en;
    logic xfer;
  } ctl_t;
endpackage

// File: rtl/gcc_rst_sync.sv
module gcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/gcc_ctl.sv
module gcc_ctl
  import gcc_pkg::*;
#(
  parameter logic [CTL_W-1:0] CTL_ADDR = 8'h13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [CTL_W-1:0] wr_addr,
  input  logic [CTL_W-1:0] wr_data,
  output logic             ctl_en_o,
  output logic             shift_en_o,
  output logic             clr_en_o,
  output logic             load_en_o,
  output logic [1:0]       din_o
);
  ctl_t ctl_q, ctl_d;
  logic ctl_we;
  logic sclk_prev_q, sclk_prev_d;
  logic load_prev_q, load_prev_d;
  logic unused_bits;

  // next state
  always_comb begin
    ctl_we      = wr_stb && (wr_addr == CTL_ADDR);
    ctl_d       = ctl_t'(wr_data);
    sclk_prev_d = ctl_q.sclk;
    load_prev_d = ctl_q.load;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q       <= '0;
      sclk_prev_q <= 1'b0;
      load_prev_q <= 1'b0;
    end else begin
      if (ctl_we) ctl_q <= ctl_d;
      sclk_prev_q <= sclk_prev_d;
      load_prev_q <= load_prev_d;
    end
  end

  // strobes
  always_comb begin
    ctl_en_o   = ctl_q.en;
    clr_en_o   = ctl_q.en && !ctl_q.run_n;
    shift_en_o = ctl_q.en && ctl_q.run_n && ctl_q.sclk && !sclk_prev_q;
    load_en_o  = ctl_q.en && ctl_q.load && !load_prev_q;
    din_o      = {ctl_q.db, ctl_q.da};
  end

  assign unused_bits = ^{ctl_q.spare, ctl_q.xfer};
endmodule

// File: rtl/gcc_chain.sv
module gcc_chain
  import gcc_pkg::*;
#(
  parameter int               NPADS   = 4,
  parameter logic [CFG_W-1:0] CFG_RST = 13'h1809,
  localparam int              CHAIN_W = NPADS * CFG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               clr_en,
  input  logic               load_en,
  input  logic               din,
  output logic [CHAIN_W-1:0] stage_o,
  output logic [CHAIN_W-1:0] cfg_o
);
  logic [CHAIN_W-1:0] stage_q, stage_d;
  logic               stage_we;

  // next state: clear wins over shift
  always_comb begin
    stage_we = shift_en || clr_en;
    if (clr_en) stage_d = '0;
    else        stage_d = {stage_q[CHAIN_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (stage_we) stage_q <= stage_d;
  end

  assign stage_o = stage_q;

  // per-slot active configuration
  for (genvar p = 0; p < NPADS; p++) begin : g_slot
    logic [CFG_W-1:0] act_q, act_d;

    always_comb act_d = stage_q[p*CFG_W +: CFG_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       act_q <= CFG_RST;
      else if (load_en) act_q <= act_d;
    end

    assign cfg_o[p*CFG_W +: CFG_W] = act_q;
  end
endmodule

// File: rtl/gpio_cfg_chain_ctrl.sv
module gpio_cfg_chain_ctrl
  import gcc_pkg::*;
#(
  parameter int               NPADS    = 4,
  parameter logic [CTL_W-1:0] CTL_ADDR = 8'h13,
  parameter logic [CFG_W-1:0] CFG_RST  = 13'h1809
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_stb,
  input  logic [CTL_W-1:0]         wr_addr,
  input  logic [CTL_W-1:0]         wr_data,
  output logic [NPADS*CFG_W-1:0]   cfg_a_o,
  output logic [NPADS*CFG_W-1:0]   cfg_b_o
);
  localparam int CHAIN_W = NPADS * CFG_W;
  localparam int NCHAIN  = 2;

  logic                           rst_n_s;
  logic                           ctl_en;
  logic                           shift_en;
  logic                           clr_en;
  logic                           load_en;
  logic [NCHAIN-1:0]              din_c;
  logic [NCHAIN-1:0][CHAIN_W-1:0] stage_c;
  logic [NCHAIN-1:0][CHAIN_W-1:0] cfg_c;

  gcc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  gcc_ctl #(.CTL_ADDR(CTL_ADDR)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ctl_en_o   (ctl_en),
    .shift_en_o (shift_en),
    .clr_en_o   (clr_en),
    .load_en_o  (load_en),
    .din_o      (din_c)
  );

  for (genvar c = 0; c < NCHAIN; c++) begin : g_chain
    gcc_chain #(.NPADS(NPADS), .CFG_RST(CFG_RST)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .shift_en (shift_en),
      .clr_en   (clr_en),
      .load_en  (load_en),
      .din      (din_c[c]),
      .stage_o  (stage_c[c]),
      .cfg_o    (cfg_c[c])
    );
  end

  assign cfg_a_o = cfg_c[0];
  assign cfg_b_o = cfg_c[1];
endmodule

// File: rtl/gcc_chk.sv
module gcc_chk #(
  parameter int CHAIN_W = 52
) (
  input logic               clk,
  input logic               rst_n_s,
  input logic               ctl_en,
  input logic               shift_en,
  input logic               clr_en,
  input logic               load_en,
  input logic [1:0]         din,
  input logic [CHAIN_W-1:0] stage_a,
  input logic [CHAIN_W-1:0] stage_b,
  input logic [CHAIN_W-1:0] cfg_a,
  input logic [CHAIN_W-1:0] cfg_b
);
  a_r3_single_shift: assert property (@(posedge clk) disable iff (!rst_n_s)
    shift_en |=> !shift_en);

  a_r4_chain_a_path: assert property (@(posedge clk) disable iff (!rst_n_s)
    (shift_en && !clr_en) |=> stage_a == {$past(stage_a[CHAIN_W-2:0]), $past(din[0])});

  a_r5_chain_b_path: assert property (@(posedge clk) disable iff (!rst_n_s)
    (shift_en && !clr_en) |=> stage_b == {$past(stage_b[CHAIN_W-2:0]), $past(din[1])});

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ctl_en |=> ($stable(stage_a) && $stable(stage_b) && $stable(cfg_a) && $stable(cfg_b)));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n_s)
    clr_en |=> (stage_a == '0 && stage_b == '0));

  a_r8_hold_active: assert property (@(posedge clk) disable iff (!rst_n_s)
    !load_en |=> ($stable(cfg_a) && $stable(cfg_b)));

  a_r8_load_copy: assert property (@(posedge clk) disable iff (!rst_n_s)
    load_en |=> (cfg_a == $past(stage_a) && cfg_b == $past(stage_b)));

  a_r10_load_pre_shift: assert property (@(posedge clk) disable iff (!rst_n_s)
    (load_en && shift_en && !clr_en) |=> (cfg_a[CHAIN_W-2:0] == stage_a[CHAIN_W-1:1]));
endmodule

bind gpio_cfg_chain_ctrl gcc_chk #(.CHAIN_W(CHAIN_W)) u_chk (
  .clk      (clk),
  .rst_n_s  (rst_n_s),
  .ctl_en   (ctl_en),
  .shift_en (shift_en),
  .clr_en   (clr_en),
  .load_en  (load_en),
  .din      (din_c),
  .stage_a  (stage_c[0]),
  .stage_b  (stage_c[1]),
  .cfg_a    (cfg_c[0]),
  .cfg_b    (cfg_c[1])
);

// File: tb/sim_gpio_cfg_chain_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_cfg_chain_ctrl;
  localparam int NP   = 4;
  localparam int W    = 13;
  localparam int CW   = NP * W;
  localparam logic [7:0] ADR = 8'h13;
  localparam logic [7:0] EN  = 8'h02;
  localparam logic [7:0] RUN = 8'h04;
  localparam logic [7:0] LD  = 8'h08;
  localparam logic [7:0] CK  = 8'h10;
  localparam logic [7:0] DA  = 8'h20;
  localparam logic [7:0] DB  = 8'h40;
  localparam logic [W-1:0] DEF = 13'h1809;
  localparam int NV = 5;
  // {chain A word, chain B word}; each is also the expected slot 0 value after its load
  localparam logic [2*W-1:0] VEC [NV] = '{
    {13'h1809, 13'h0403}, {13'h1FFF, 13'h0000}, {13'h1555, 13'h0AAA},
    {13'h0001, 13'h1000}, {13'h0C3A, 13'h13C5}};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_stb;
  logic [7:0]    wr_addr;
  logic [7:0]    wr_data;
  logic [CW-1:0] cfg_a_o;
  logic [CW-1:0] cfg_b_o;

  int checks = 0;
  int errors = 0;
  logic [CW-1:0] m_sa, m_sb, m_ca, m_cb;

  always #5 clk = ~clk;

  gpio_cfg_chain_ctrl #(.NPADS(NP), .CTL_ADDR(ADR), .CFG_RST(DEF)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_a_o(cfg_a_o), .cfg_b_o(cfg_b_o));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic shift_bit(input logic a, input logic b);
    logic [7:0] d;
    d = EN | RUN | (a ? DA : 8'h00) | (b ? DB : 8'h00);
    wr(ADR, d);
    wr(ADR, d | CK);
    m_sa = {m_sa[CW-2:0], a};
    m_sb = {m_sb[CW-2:0], b};
  endtask

  task automatic shift_words(input logic [W-1:0] wa, input logic [W-1:0] wb);
    for (int i = W - 1; i >= 0; i--) shift_bit(wa[i], wb[i]);
    wr(ADR, EN | RUN);
  endtask

  task automatic do_load();
    wr(ADR, EN | RUN | LD);
    m_ca = m_sa; m_cb = m_sb;
    wr(ADR, EN | RUN);
  endtask

  task automatic check_all(input string req);
    for (int p = 0; p < NP; p++) begin
      chk({req, " chain A"}, cfg_a_o[p*W +: W], m_ca[p*W +: W]);
      chk({req, " chain B"}, cfg_b_o[p*W +: W], m_cb[p*W +: W]);
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_sa = '0; m_sb = '0;
    m_ca = {NP{DEF}}; m_cb = {NP{DEF}};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wr_stb = 1'b0; wr_addr = '0; wr_data = '0;
    apply_reset();
    check_all("R9 reset default");

    // R3: first write with clock low must not shift
    wr(ADR, EN | RUN | DA | DB);
    do_load();
    check_all("R3 no edge after reset");

    // R4 R5: table walk, words move one slot per 13 clocks
    for (int v = 0; v < NV; v++) begin
      shift_words(VEC[v][2*W-1:W], VEC[v][W-1:0]);
      do_load();
      chk("R4 slot0 A", cfg_a_o[W-1:0], VEC[v][2*W-1:W]);
      chk("R5 slot0 B", cfg_b_o[W-1:0], VEC[v][W-1:0]);
      if (v >= NP - 1) begin
        chk("R4 last slot A", cfg_a_o[(NP-1)*W +: W], VEC[v-(NP-1)][2*W-1:W]);
        chk("R5 last slot B", cfg_b_o[(NP-1)*W +: W], VEC[v-(NP-1)][W-1:0]);
      end
      check_all("R4 R5 chain model");
    end

    // R1: other address ignored
    wr(8'h12, EN | RUN | CK | DA | LD);
    wr(8'h12, EN | RUN);
    do_load();
    check_all("R1 wrong address");

    // R6: stage words differ from active, then disabled activity
    shift_words(13'h0ABC, 13'h1F0F);
    wr(ADR, RUN | DA);
    wr(ADR, RUN | DA | CK);
    wr(ADR, RUN | LD);
    wr(ADR, LD);
    wr(ADR, 8'h00);
    check_all("R6 disabled load and clear ignored");
    wr(ADR, EN | RUN);
    do_load();
    check_all("R6 disabled clock ignored");

    // R10: clock and load rise in the same write
    wr(ADR, EN | RUN | DA);
    wr(ADR, EN | RUN | DA | CK | LD);
    m_ca = m_sa; m_cb = m_sb;
    m_sa = {m_sa[CW-2:0], 1'b1};
    m_sb = {m_sb[CW-2:0], 1'b0};
    wr(ADR, EN | RUN);
    check_all("R10 load takes pre-shift words");
    do_load();
    check_all("R10 chain shifted once");

    // R7: clear held, clocks suppressed
    wr(ADR, EN);
    wr(ADR, EN | CK | DA | DB);
    wr(ADR, EN);
    m_sa = '0; m_sb = '0;
    wr(ADR, EN | LD);
    m_ca = '0; m_cb = '0;
    wr(ADR, EN);
    check_all("R7 clear");
    wr(ADR, EN | RUN);
    do_load();
    check_all("R7 run without spurious shift");

    // R2: bit 0 and bit 7 have no function
    wr(ADR, EN | RUN | 8'h81);
    wr(ADR, EN | RUN);
    do_load();
    check_all("R2 unused bits");

    // R9: reset in mid-run
    shift_words(13'h1234, 13'h0765);
    apply_reset();
    check_all("R9 reset mid-run");
    do_load();
    check_all("R9 stages cleared by reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule